// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block steps through a multiple-register load or store one word at a time. A start pulse supplies a base address, a 16-bit register mask and three control bits: pre/post indexing, up/down direction and base writeback. The block then produces one transfer per cycle. Each transfer carries a word address, the register number and a valid strobe. A last flag marks the final transfer. The memory side consumes the address and register pair. A register file writes the updated base back when the writeback strobe fires.

Registers always go out in ascending index order, and addresses always rise by one word per transfer. The four indexing modes change only the starting address and the sign of the base update. An empty mask is legal. It transfers a single register, the top one, and uses sixteen words in place of the register count when it computes the offset.

Top module: `blk_xfer_seq`

## Requirements
- R1: Post-increment mode (pre_idx=0, up=1) gives base as the first transfer address.
- R2: Pre-increment mode (pre_idx=1, up=1) gives base + 4 as the first transfer address.
- R3: Pre-decrement mode (pre_idx=1, up=0) gives base − 4·N as the first transfer address, where N is the number of set bits in reg_list.
- R4: Post-decrement mode (pre_idx=0, up=0) gives base − (4·N − 4) as the first transfer address.
- R5: The block sends the set bits of reg_list in ascending index order, one per cycle with xfer_valid high. The first transfer appears in the cycle after start is sampled, and each later address is the previous one plus 4.
- R6: xfer_last is high with the final valid transfer and low on every other cycle.
- R7: An all-zero reg_list produces exactly one transfer, of register 15. The offset 4·N is replaced by 0x40 in every mode, so the post-decrement first address is base − 0x3C.
- R8: When wb_en was set at start, wb_valid is high for exactly one cycle, the cycle after the last transfer, with wb_value = base + 4·N for up=1 or base − 4·N for up=0 (0x40 replacing 4·N for an empty list). When wb_en was clear, wb_valid stays low.
- R9: xfer_addr[1:0] is always 0, even when the base is not word aligned.
- R10: A start pulse is ignored from the cycle it is accepted until the writeback cycle ends, and the sequence in progress is unchanged.
- R11: While reset is asserted and right after it, xfer_valid, xfer_last and wb_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (sampled only when idle) |
| base_addr | input | 32 | Base address |
| reg_list | input | 16 | Register mask, bit i selects register i |
| pre_idx | input | 1 | 1 = adjust before the first access, 0 = after |
| up | input | 1 | 1 = increment, 0 = decrement |
| wb_en | input | 1 | Request base writeback |
| xfer_valid | output | 1 | Transfer present this cycle |
| xfer_addr | output | 32 | Word-aligned transfer address |
| xfer_reg | output | 4 | Register index of this transfer |
| xfer_last | output | 1 | Final transfer of the sequence |
| wb_valid | output | 1 | Writeback strobe |
| wb_value | output | 32 | Updated base value |

## Verification
The assertions take the stepping rules as given: addresses rise by 4 and register numbers strictly increase between back-to-back transfers, and the writeback strobe can only follow a last transfer. They make no assumptions about the base alignment or the mask contents. The directed stimulus holds start for a single cycle, except in the scenario that deliberately keeps it high with different operands during a run. It covers full, sparse, single-bit and empty masks in all four modes, with both aligned and unaligned bases.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/blk_xfer_calc.sv
// Start address and updated base for one block transfer.
module blk_xfer_calc #(
  parameter int ADDR_W     = 32,
  parameter int NREGS      = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [NREGS-1:0]  regs,
  input  logic              pre,
  input  logic              inc,
  output logic [ADDR_W-1:0] first_addr,
  output logic [ADDR_W-1:0] new_base
);
  localparam int CNT_W = $clog2(NREGS + 1);
  localparam logic [ADDR_W-1:0] EMPTY_OFS = ADDR_W'(NREGS * WORD_BYTES);
  localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(WORD_BYTES);

  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] ofs;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NREGS; i++) cnt = cnt + CNT_W'(regs[i]);
  end

  assign ofs = (cnt == '0) ? EMPTY_OFS : ADDR_W'(cnt) * STEP;

  always_comb begin
    unique case ({pre, inc})
      2'b11:   first_addr = base + STEP;          // increment before
      2'b01:   first_addr = base;                 // increment after
      2'b10:   first_addr = base - ofs;           // decrement before
      default: first_addr = base - (ofs - STEP);  // decrement after
    endcase
  end

  assign new_base = inc ? (base + ofs) : (base - ofs);
endmodule

// File: rtl/blk_xfer_pick.sv
// Lowest set bit of the remaining mask, the mask without it, and a last flag.
module blk_xfer_pick #(
  parameter int NREGS = 16
) (
  input  logic [NREGS-1:0]         mask,
  output logic [$clog2(NREGS)-1:0] idx,
  output logic [NREGS-1:0]         rest,
  output logic                     single
);
  localparam int IDX_W = $clog2(NREGS);

  always_comb begin
    idx = '0;
    for (int i = NREGS - 1; i >= 0; i--) begin
      if (mask[i]) idx = IDX_W'(i);
    end
  end

  assign rest   = mask & (mask - NREGS'(1));
  assign single = (rest == '0);
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int ADDR_W     = 32,
  parameter int NREGS      = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [ADDR_W-1:0]        base_addr,
  input  logic [NREGS-1:0]         reg_list,
  input  logic                     pre_idx,
  input  logic                     up,
  input  logic                     wb_en,
  output logic                     xfer_valid,
  output logic [ADDR_W-1:0]        xfer_addr,
  output logic [$clog2(NREGS)-1:0] xfer_reg,
  output logic                     xfer_last,
  output logic                     wb_valid,
  output logic [ADDR_W-1:0]        wb_value
);
  import blk_xfer_pkg::*;

  localparam int ALIGN_W = $clog2(WORD_BYTES);
  localparam int IDX_W   = $clog2(NREGS);
  localparam logic [NREGS-1:0] TOP_ONLY = NREGS'(1) << (NREGS - 1);

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [NREGS-1:0]  mask_q, mask_d;
  logic              wb_q, wb_d;
  logic [ADDR_W-1:0] nb_q, nb_d;

  logic [ADDR_W-1:0] calc_first, calc_nb;
  logic [NREGS-1:0]  pick_rest;
  logic [IDX_W-1:0]  pick_idx;
  logic              pick_single;
  logic              accept;

  blk_xfer_calc #(.ADDR_W(ADDR_W), .NREGS(NREGS), .WORD_BYTES(WORD_BYTES)) calc_i (
    .base       (base_addr),
    .regs       (reg_list),
    .pre        (pre_idx),
    .inc        (up),
    .first_addr (calc_first),
    .new_base   (calc_nb)
  );

  blk_xfer_pick #(.NREGS(NREGS)) pick_i (
    .mask   (mask_q),
    .idx    (pick_idx),
    .rest   (pick_rest),
    .single (pick_single)
  );

  assign accept = (state_q == ST_IDLE) && start;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    mask_d  = mask_q;
    wb_d    = wb_q;
    nb_d    = nb_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_XFER;
          addr_d  = calc_first;
          mask_d  = (reg_list == '0) ? TOP_ONLY : reg_list;
          wb_d    = wb_en;
          nb_d    = calc_nb;
        end
      end
      ST_XFER: begin
        addr_d = addr_q + ADDR_W'(WORD_BYTES);
        mask_d = pick_rest;
        if (pick_single) state_d = ST_DONE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      mask_q  <= '0;
      wb_q    <= 1'b0;
      nb_q    <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      mask_q  <= mask_d;
      wb_q    <= wb_d;
      nb_q    <= nb_d;
    end
  end

  assign xfer_valid = (state_q == ST_XFER);
  assign xfer_addr  = {addr_q[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
  assign xfer_reg   = pick_idx;
  assign xfer_last  = xfer_valid && pick_single;
  assign wb_valid   = (state_q == ST_DONE) && wb_q;
  assign wb_value   = nb_q;
endmodule

// File: rtl/blk_xfer_seq_chk.sv
module blk_xfer_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xfer_valid,
  input logic [ADDR_W-1:0] xfer_addr,
  input logic [IDX_W-1:0]  xfer_reg,
  input logic              xfer_last,
  input logic              wb_valid
);
  assert_last_has_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_last |-> xfer_valid);

  assert_last_ends_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_last) |=> !xfer_valid);

  assert_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> (xfer_addr[1:0] == 2'b00));

  assert_run_continues_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_last) |=> xfer_valid);

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_last) |=> (xfer_addr == $past(xfer_addr) + ADDR_W'(4)));

  assert_reg_ascends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_last) |=> (xfer_reg > $past(xfer_reg)));

  assert_wb_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> ($past(xfer_last) && !xfer_valid));

  assert_wb_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |=> !wb_valid);
endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(.ADDR_W(ADDR_W), .IDX_W($clog2(NREGS))) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .xfer_valid (xfer_valid),
  .xfer_addr  (xfer_addr),
  .xfer_reg   (xfer_reg),
  .xfer_last  (xfer_last),
  .wb_valid   (wb_valid)
);

// File: tb/blk_xfer_seq_tb_top.sv
`timescale 1ns/1ps
module blk_xfer_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] base_addr;
  logic [15:0] reg_list;
  logic        pre_idx, up, wb_en;
  logic        xfer_valid, xfer_last, wb_valid;
  logic [31:0] xfer_addr, wb_value;
  logic [3:0]  xfer_reg;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  blk_xfer_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .reg_list(reg_list), .pre_idx(pre_idx), .up(up), .wb_en(wb_en),
    .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_reg(xfer_reg),
    .xfer_last(xfer_last), .wb_valid(wb_valid), .wb_value(wb_value)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Runs one sequence and checks every cycle; hold_start keeps start high
  // with different operands during the run.
  task automatic run_seq(input logic [31:0] b, input logic [15:0] l,
                         input bit p, input bit u, input bit w,
                         input string req, input bit hold_start);
    int          cnt = 0;
    logic [31:0] ofs, first, nb;
    logic [15:0] eff;
    int          k = 0;
    for (int i = 0; i < 16; i++) cnt += l[i];
    ofs = (cnt == 0) ? 32'h40 : 32'(cnt * 4);
    if (p && u)       first = b + 32'd4;
    else if (u)       first = b;
    else if (p)       first = b - ofs;
    else              first = b - (ofs - 32'd4);
    nb  = u ? b + ofs : b - ofs;
    eff = (l == 16'h0) ? 16'h8000 : l;

    @(negedge clk);
    base_addr = b; reg_list = l; pre_idx = p; up = u; wb_en = w; start = 1'b1;
    @(negedge clk);
    if (hold_start) begin
      base_addr = ~b; reg_list = ~l; pre_idx = ~p; up = ~u; wb_en = ~w;
    end else start = 1'b0;
    for (int i = 0; i < 16; i++) begin
      if (eff[i]) begin
        logic [31:0] ea;
        bit          el;
        ea = (first + 32'(k * 4)) & 32'hFFFF_FFFC;
        el = ((eff >> (i + 1)) == 16'h0);
        check(xfer_valid == 1'b1, req, "valid", 64'(xfer_valid), 64'd1);
        check(xfer_addr == ea, req, "addr", 64'(xfer_addr), 64'(ea));
        check(xfer_reg == 4'(i), req, "reg", 64'(xfer_reg), 64'(i));
        check(xfer_last == el, "R6", "last", 64'(xfer_last), 64'(el));
        check(wb_valid == 1'b0, "R8", "wb early", 64'(wb_valid), 64'd0);
        k++;
        if (el) start = 1'b0;
        @(negedge clk);
      end
    end
    check(xfer_valid == 1'b0, "R6", "valid after last", 64'(xfer_valid), 64'd0);
    check(wb_valid == w, "R8", "wb strobe", 64'(wb_valid), 64'(w));
    if (w) check(wb_value == nb, "R8", "wb value", 64'(wb_value), 64'(nb));
    @(negedge clk);
    check(wb_valid == 1'b0 && xfer_valid == 1'b0, "R10", "idle after run",
          64'({wb_valid, xfer_valid}), 64'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; base_addr = '0; reg_list = '0;
    pre_idx = 0; up = 0; wb_en = 0;
    repeat (3) @(negedge clk);
    check(!xfer_valid && !xfer_last && !wb_valid, "R11", "outputs in reset",
          64'({xfer_valid, xfer_last, wb_valid}), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!xfer_valid && !xfer_last && !wb_valid, "R11", "outputs after reset",
          64'({xfer_valid, xfer_last, wb_valid}), 64'd0);
  endtask

  task automatic t_modes();
    run_seq(32'h0000_1000, 16'h00F1, 1'b0, 1'b1, 1'b1, "R1", 1'b0);
    run_seq(32'h0000_2000, 16'h8421, 1'b1, 1'b1, 1'b1, "R2", 1'b0);
    run_seq(32'h0000_3000, 16'h0C06, 1'b1, 1'b0, 1'b1, "R3", 1'b0);
    run_seq(32'h0000_4000, 16'hA00A, 1'b0, 1'b0, 1'b1, "R4", 1'b0);
    run_seq(32'h8000_0000, 16'hFFFF, 1'b0, 1'b0, 1'b0, "R5", 1'b0);
    run_seq(32'h0000_0100, 16'h0010, 1'b1, 1'b1, 1'b0, "R6", 1'b0);
  endtask

  task automatic t_empty();
    run_seq(32'h0000_5000, 16'h0000, 1'b0, 1'b1, 1'b1, "R7", 1'b0);
    run_seq(32'h0000_5000, 16'h0000, 1'b1, 1'b1, 1'b1, "R7", 1'b0);
    run_seq(32'h0000_5000, 16'h0000, 1'b1, 1'b0, 1'b1, "R7", 1'b0);
    run_seq(32'h0000_5000, 16'h0000, 1'b0, 1'b0, 1'b1, "R7", 1'b0);
  endtask

  task automatic t_align();
    run_seq(32'h0000_6003, 16'h0301, 1'b1, 1'b1, 1'b1, "R9", 1'b0);
    run_seq(32'h0000_7002, 16'h0006, 1'b0, 1'b0, 1'b0, "R9", 1'b0);
  endtask

  task automatic t_busy();
    run_seq(32'h0000_9000, 16'h1248, 1'b0, 1'b1, 1'b1, "R10", 1'b1);
    run_seq(32'h0000_A000, 16'h0000, 1'b1, 1'b0, 1'b0, "R10", 1'b1);
  endtask

  initial begin
    t_reset();
    t_modes();
    t_empty();
    t_align();
    t_busy();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule